// File: doc/BRIEF.md
# Receive FIFO With Status Tags

This block is the character store that sits behind a serial receiver. Each finished character reaches it as a byte together with three error tags: parity, framing and break. The block keeps up to eight of these characters in arrival order. A single holding stage stands in front of the buffer and plays the part of the receive shift register. It absorbs a ninth character when the buffer is full. If characters keep arriving before the host frees a slot, later ones overwrite that ninth character, and an overrun flag records that data was lost.

The host sees the tags of pending characters in one of two ways. In per-character mode it gets the tags of the character at the head of the buffer. In accumulated mode it gets the OR of the tags of every character that has reached the head since the last error-clear command. An optional automatic flow-control output asks the far transmitter to pause once a start bit is seen while the buffer is full. That output is gated by a general-purpose output-port bit.

Top module: `rx_tag_fifo`

## Requirements
- R1: After `rst_n` is sampled low, `rx_rdy`, `ffull`, `st_ovr`, all three status bits and `rd_data` are 0, and `rts_n` equals `~port_bit`.
- R2: The buffer holds up to eight characters in arrival order. `rx_rdy` is 1 while at least one is stored, and `ffull` is 1 while all eight are stored. A pulse on `rd_en` with a non-empty buffer pops the head, and the popped byte appears on `rd_data` from the next clock edge.
- R3: Each stored byte keeps its own parity, framing and break tags. With `blk_mode`=0, `st_perr`/`st_ferr`/`st_brk` show the tags of the head entry, and they are 0 when the buffer is empty.
- R4: With `blk_mode`=1, each status bit is the OR of that tag over every character that has been at the head since the last `err_clr`. `err_clr` drops the accumulated history, so the bits then show only the current head.
- R5: Reading the status has no side effect. Without `rd_en`, the head entry, the status bits and `rx_rdy` stay unchanged.
- R6: A character that arrives while the buffer is full is held in the holding stage. The cycle after a slot frees, it moves into the buffer behind the older entries.
- R7: While the buffer stays full, each newer character overwrites the held one. Only the last of them is later delivered.
- R8: `st_ovr` is set by `start_seen` while the buffer is full and the holding stage is occupied. It is not set when the holding stage is empty. Once set, it stays set until `err_clr` or `rx_rst`.
- R9: With `auto_rts_en`=1 and `port_bit`=1, `rts_n` goes high one cycle after `start_seen` is seen with a full buffer. It returns low in the same cycle that the buffer stops being full. With `auto_rts_en`=0, `rts_n` equals `~port_bit`.
- R10: `rts_n` is the NAND of `port_bit` and the internal send request, so `port_bit`=0 keeps `rts_n` high whatever the buffer holds.
- R11: A one-cycle `rx_rst` empties the buffer, discards the held character, and clears `st_ovr`, the accumulated status and the flow-control request. The next character written is the next one read.
- R12: `rd_en` on an empty buffer leaves `rd_data` at its last value and moves no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_rst | input | 1 | Receiver reset command, one-cycle pulse |
| chr_valid | input | 1 | Character-done strobe |
| chr_data | input | 8 | Received byte |
| chr_perr | input | 1 | Parity-error tag of the byte |
| chr_ferr | input | 1 | Framing-error tag of the byte |
| chr_brk | input | 1 | Break tag of the byte |
| start_seen | input | 1 | Valid start bit detected, one-cycle pulse |
| rd_en | input | 1 | Host data read, pops the head |
| err_clr | input | 1 | Error-clear command |
| blk_mode | input | 1 | 0: per-character status, 1: accumulated status |
| auto_rts_en | input | 1 | Enable automatic flow control |
| port_bit | input | 1 | Output-port register bit gating the RTS pin |
| rd_data | output | 8 | Last byte popped |
| rx_rdy | output | 1 | At least one character stored |
| ffull | output | 1 | All eight entries occupied |
| st_perr | output | 1 | Reported parity-error status |
| st_ferr | output | 1 | Reported framing-error status |
| st_brk | output | 1 | Reported break status |
| st_ovr | output | 1 | Overrun flag |
| rts_n | output | 1 | Active-low request-to-send pin |

## Verification
The bench targets the full-buffer boundary. After one read, `ffull` must fall and then rise again one cycle later as the held ninth byte moves in. A design that dropped the held byte, or delivered an older overwritten one, would put the wrong value last in the read sequence. It also checks that a start bit with an empty holding stage leaves `st_ovr` clear, and that the flag survives every later read until it is cleared. In accumulated mode it checks that the history outlives the pops but not `err_clr`; a design that reported only the head would lose a parity flag that has already left. Empty reads and a receiver reset in the middle of an overrun are checked for stale data and for misaligned pointers.

// File: rtl/rx_tag_pkg.sv
// Package: shared types for the tagged receive buffer.
// Assumes: the three error tags travel together as one packed group.
package rx_tag_pkg;
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_tags_t;
endpackage

// File: rtl/rx_tag_store.sv
// Module: circular buffer of bytes with per-entry error tags.
// Assumes: the caller never writes when full and never pops when empty;
// flush realigns both pointers and empties the buffer in one cycle.
module rx_tag_store
    import rx_tag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  rx_tags_t          wr_tags,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] head_data,
    output rx_tags_t          head_tags,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] data_mem [DEPTH];
    rx_tags_t          tag_mem  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    assign full      = (count == FULL_CNT);
    assign empty     = (count == '0);
    assign head_data = data_mem[rd_ptr];
    assign head_tags = tag_mem[rd_ptr];

    // Storage write: place byte and tags at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            data_mem[wr_ptr] <= wr_data;
            tag_mem[wr_ptr]  <= wr_tags;
        end
    end

    // Pointer and occupancy update, with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en)
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_pop)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: the holding-stage logic must never push into a full buffer.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);

    // R2: a lone write grows the occupancy by exactly one.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_pop && !flush) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/rx_hold_stage.sv
// Module: single-character holding stage in front of the buffer,
// plus the sticky overrun flag.
// Assumes: buf_full is the registered occupancy state; a slot freed by a
// read is seen one cycle later, when the held character moves in.
module rx_hold_stage
    import rx_tag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  rx_tags_t          chr_tags,
    input  logic              start_seen,
    input  logic              err_clr,
    input  logic              buf_full,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output rx_tags_t          wr_tags,
    output logic              ovr
);
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;
    rx_tags_t          hold_tags;
    logic              hold_move, direct_wr, to_hold;

    // Write-source selection: the held character has priority over a new one.
    always_comb begin
        hold_move = hold_vld && !buf_full;
        direct_wr = chr_valid && !hold_vld && !buf_full;
        to_hold   = chr_valid && !direct_wr;
        wr_en     = hold_move || direct_wr;
        wr_data   = hold_move ? hold_data : chr_data;
        wr_tags   = hold_move ? hold_tags : chr_tags;
    end

    // Holding register: capture, overwrite, or release into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hold_vld  <= 1'b0;
            hold_data <= '0;
            hold_tags <= '0;
        end else if (to_hold) begin
            hold_vld  <= 1'b1;
            hold_data <= chr_data;
            hold_tags <= chr_tags;
        end else if (hold_move) begin
            hold_vld  <= 1'b0;
        end
    end

    // Overrun flag: set by a start bit with nowhere to go, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            ovr <= 1'b0;
        else if (start_seen && buf_full && hold_vld)
            ovr <= 1'b1;
        else if (err_clr)
            ovr <= 1'b0;
    end

    // R6: with no new character, a held one leaves as soon as a slot is free.
    assert_hold_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !buf_full && !chr_valid && !flush) |=> !hold_vld);

    // R8: overrun stays set until the clear command or a receiver reset.
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !err_clr && !flush) |=> ovr);
endmodule

// File: rtl/rx_status_merge.sv
// Module: forms the reported error status from the head entry's tags,
// either per character or accumulated since the last clear.
// Assumes: the head tags are valid only while head_valid is high.
module rx_status_merge
    import rx_tag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     err_clr,
    input  logic     blk_mode,
    input  logic     head_valid,
    input  rx_tags_t head_tags,
    output rx_tags_t rep_tags
);
    rx_tags_t acc;
    rx_tags_t head_live;

    assign head_live = head_valid ? head_tags : rx_tags_t'('0);

    // Accumulator: OR in every tag that sits at the head, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || err_clr)
            acc <= '0;
        else
            acc <= acc | head_live;
    end

    // Reported status: head only, or head merged with history.
    always_comb begin
        if (blk_mode)
            rep_tags = acc | head_live;
        else
            rep_tags = head_live;
    end

    // R4: accumulated bits are never lost without a clear or a reset.
    assert_block_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr && !flush) |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/rx_rts_ctrl.sv
// Module: automatic request-to-send control for the receive side.
// Assumes: start_seen is a one-cycle pulse from the receiver; the pin is
// the NAND of the output-port bit and the internal send request.
module rx_rts_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic start_seen,
    input  logic buf_full,
    input  logic auto_en,
    input  logic port_bit,
    output logic rts_n
);
    logic stop_req;
    logic send_req;

    // Stop request: raised by a start bit into a full buffer, dropped on a free slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            stop_req <= 1'b0;
        else if (start_seen && buf_full)
            stop_req <= 1'b1;
        else if (!buf_full)
            stop_req <= 1'b0;
    end

    // Pin drive: the request is withdrawn only while the buffer is still full.
    always_comb begin
        send_req = auto_en ? !(stop_req && buf_full) : 1'b1;
        rts_n    = !(port_bit && send_req);
    end
endmodule

// File: rtl/rx_tag_fifo.sv
// Module: top of the tagged receive buffer. Joins the holding stage,
// the storage, the status merge and the flow-control output; registers
// the read data.
// Assumes: all strobes are synchronous one-cycle pulses; rx_rst wins
// over any simultaneous write or read.
module rx_tag_fifo
    import rx_tag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_rst,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              chr_brk,
    input  logic              start_seen,
    input  logic              rd_en,
    input  logic              err_clr,
    input  logic              blk_mode,
    input  logic              auto_rts_en,
    input  logic              port_bit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_rdy,
    output logic              ffull,
    output logic              st_perr,
    output logic              st_ferr,
    output logic              st_brk,
    output logic              st_ovr,
    output logic              rts_n
);
    rx_tags_t          in_tags, wr_tags, head_tags, rep_tags;
    logic              wr_en, rd_pop, buf_full, buf_empty;
    logic [DATA_W-1:0] wr_data, head_data;

    assign in_tags = '{brk: chr_brk, ferr: chr_ferr, perr: chr_perr};
    assign rd_pop  = rd_en && !buf_empty && !rx_rst;
    assign rx_rdy  = !buf_empty;
    assign ffull   = buf_full;
    assign st_perr = rep_tags.perr;
    assign st_ferr = rep_tags.ferr;
    assign st_brk  = rep_tags.brk;

    rx_hold_stage #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_rst),
        .chr_valid  (chr_valid),
        .chr_data   (chr_data),
        .chr_tags   (in_tags),
        .start_seen (start_seen),
        .err_clr    (err_clr),
        .buf_full   (buf_full),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_tags    (wr_tags),
        .ovr        (st_ovr)
    );

    rx_tag_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_tags   (wr_tags),
        .rd_pop    (rd_pop),
        .head_data (head_data),
        .head_tags (head_tags),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    rx_status_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_rst),
        .err_clr    (err_clr),
        .blk_mode   (blk_mode),
        .head_valid (!buf_empty),
        .head_tags  (head_tags),
        .rep_tags   (rep_tags)
    );

    rx_rts_ctrl u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_rst),
        .start_seen (start_seen),
        .buf_full   (buf_full),
        .auto_en    (auto_rts_en),
        .port_bit   (port_bit),
        .rts_n      (rts_n)
    );

    // Read data register: load the head on a pop, otherwise keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_pop)
            rd_data <= head_data;
    end

    // R9: a start bit into a full buffer withdraws the request next cycle.
    assert_rts_negate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && ffull && auto_rts_en && port_bit && !rd_en && !rx_rst)
        |=> rts_n);

    // R11: receiver reset leaves an empty buffer with no overrun.
    assert_rxrst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (!rx_rdy && !ffull && !st_ovr));

    // R12: reading an empty buffer does not disturb the data output.
    assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_rdy && !rx_rst) |=> $stable(rd_data));
endmodule

// File: tb/tb_rx_tag_fifo.sv
module tb_rx_tag_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_rst = 1'b0, chr_valid = 1'b0;
    logic [7:0] chr_data = '0;
    logic       chr_perr = 1'b0, chr_ferr = 1'b0, chr_brk = 1'b0;
    logic       start_seen = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
    logic       blk_mode = 1'b0, auto_rts_en = 1'b1, port_bit = 1'b1;
    logic [7:0] rd_data;
    logic       rx_rdy, ffull, st_perr, st_ferr, st_brk, st_ovr, rts_n;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // Vector table: {brk, ferr, perr, data}, pushed in order, read back in order.
    localparam logic [10:0] VEC [8] = '{
        {3'b000, 8'hA5}, {3'b001, 8'h3C}, {3'b010, 8'h7E}, {3'b100, 8'h00},
        {3'b011, 8'hC3}, {3'b000, 8'h01}, {3'b110, 8'h00}, {3'b000, 8'hFF}
    };

    always #4 clk = ~clk;

    rx_tag_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .chr_valid(chr_valid),
        .chr_data(chr_data), .chr_perr(chr_perr), .chr_ferr(chr_ferr),
        .chr_brk(chr_brk), .start_seen(start_seen), .rd_en(rd_en),
        .err_clr(err_clr), .blk_mode(blk_mode), .auto_rts_en(auto_rts_en),
        .port_bit(port_bit), .rd_data(rd_data), .rx_rdy(rx_rdy),
        .ffull(ffull), .st_perr(st_perr), .st_ferr(st_ferr), .st_brk(st_brk),
        .st_ovr(st_ovr), .rts_n(rts_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] stat();
        return {st_brk, st_ferr, st_perr};
    endfunction

    task automatic push(input logic [10:0] v);
        chr_valid = 1'b1;
        {chr_brk, chr_ferr, chr_perr, chr_data} = v;
        @(negedge clk);
        chr_valid = 1'b0;
        {chr_brk, chr_ferr, chr_perr, chr_data} = '0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_start();
        start_seen = 1'b1;
        @(negedge clk);
        start_seen = 1'b0;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic pulse_rxrst();
        rx_rst = 1'b1;
        @(negedge clk);
        rx_rst = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rx_rdy", rx_rdy, 0);
        chk("R1 ffull", ffull, 0);
        chk("R1 st_ovr", st_ovr, 0);
        chk("R1 status", stat(), 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 rts_n", rts_n, 0);

        // R2 R3: table walk, fill then drain in per-character mode
        for (int i = 0; i < 8; i++) begin
            push(VEC[i]);
            chk("R2 rx_rdy while filling", rx_rdy, 1);
            chk("R2 ffull while filling", ffull, (i == 7) ? 1 : 0);
        end
        // R5: no read, nothing moves
        repeat (3) @(negedge clk);
        chk("R5 head status stable", stat(), VEC[0][10:8]);
        chk("R5 rx_rdy stable", rx_rdy, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R3 head tags", stat(), VEC[i][10:8]);
            pop();
            chk("R2 popped byte", rd_data, VEC[i][7:0]);
        end
        chk("R2 empty after drain", rx_rdy, 0);
        chk("R3 status zero when empty", stat(), 0);

        // R12: empty read keeps data and pointers
        pop();
        chk("R12 rd_data kept", rd_data, 8'hFF);
        chk("R12 still empty", rx_rdy, 0);
        push({3'b000, 8'h66});
        pop();
        chk("R12 pointers aligned", rd_data, 8'h66);

        // R6 R7 R8 R9: overrun path
        for (int i = 0; i < 8; i++) push({3'b000, 8'(8'h10 + i)});
        chk("R2 full", ffull, 1);
        chk("R9 rts before start", rts_n, 0);
        pulse_start();
        chk("R9 rts negated", rts_n, 1);
        chk("R8 no overrun with empty hold", st_ovr, 0);
        push({3'b000, 8'h20});
        pulse_start();
        chk("R8 overrun set", st_ovr, 1);
        push({3'b000, 8'h21});
        push({3'b000, 8'h22});
        chk("R6 buffer still full", ffull, 1);
        pop();
        chk("R2 head popped", rd_data, 8'h10);
        chk("R6 slot free", ffull, 0);
        chk("R9 rts reasserted", rts_n, 0);
        @(negedge clk);
        chk("R6 held byte moved in", ffull, 1);
        chk("R9 rts stays low", rts_n, 0);
        for (int i = 1; i < 8; i++) begin
            pop();
            chk("R6 order kept", rd_data, 8'(8'h10 + i));
        end
        pop();
        chk("R7 last overwrite delivered", rd_data, 8'h22);
        chk("R7 nothing else held", rx_rdy, 0);
        chk("R8 overrun sticky", st_ovr, 1);
        pulse_clr();
        chk("R8 overrun cleared", st_ovr, 0);

        // R11: receiver reset mid-overrun
        for (int i = 0; i < 9; i++) push({3'b001, 8'(8'h40 + i)});
        pulse_start();
        chk("R8 overrun again", st_ovr, 1);
        pulse_rxrst();
        chk("R11 rx_rdy", rx_rdy, 0);
        chk("R11 ffull", ffull, 0);
        chk("R11 overrun", st_ovr, 0);
        chk("R11 status", stat(), 0);
        chk("R11 rts", rts_n, 0);
        push({3'b000, 8'h55});
        repeat (2) @(negedge clk);
        pop();
        chk("R11 held byte discarded", rd_data, 8'h55);
        chk("R11 single entry", rx_rdy, 0);

        // R4: accumulated status
        blk_mode = 1'b1;
        push({3'b001, 8'h31});
        push({3'b000, 8'h32});
        push({3'b010, 8'h33});
        chk("R4 head A", stat(), 3'b001);
        pop();
        chk("R4 history keeps parity", stat(), 3'b001);
        pop();
        chk("R4 merged parity and framing", stat(), 3'b011);
        pulse_clr();
        chk("R4 clear leaves head only", stat(), 3'b010);
        pop();
        chk("R4 history after last pop", stat(), 3'b010);
        blk_mode = 1'b0;
        #1;
        chk("R3 char mode empty", stat(), 3'b000);

        // R9 R10: pin gating
        auto_rts_en = 1'b0;
        #1;
        chk("R9 auto off follows port bit", rts_n, 0);
        port_bit = 1'b0;
        #1;
        chk("R10 port bit low keeps pin high", rts_n, 1);
        auto_rts_en = 1'b1;
        #1;
        chk("R10 port bit low with auto on", rts_n, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule